// File: doc/BRIEF.md
# UART Host Register Front End

This block is the host-facing register file of a byte-wide serial port. It sits on a Wishbone bus as a slave to a 32-bit processor and uses only the low byte of the data bus. It holds the serial configuration: a 24-bit baud divisor written one byte at a time, a line control byte, an interrupt mask, watermark bytes for both queues, a receive timeout byte and an inter-character delay byte. The serial shifter, baud tick generation and interrupt logic are not part of this block.

The block contains a small transmit queue and a small receive queue. A write to the data address puts a tagged 9-bit entry in the transmit queue, and so does a write to the break address. Bit 8 of each entry tells the shifter whether the entry is ordinary data or a break request. A read of the data address takes the oldest byte out of the receive queue. A read-only status byte reports the queue levels, a sticky transmit overflow flag and three status bits supplied by the surrounding logic.

Top module: `wb_uart_regs`

## Requirements
- R1: `wbAck` rises in the cycle after a cycle in which `wbCyc` and `wbStb` are both high. It stays high for exactly one cycle per request. It never rises without a request. Register writes, queue pushes and queue pops take effect at the clock edge that ends the acknowledged cycle.
- R2: Addresses 0, 1 and 2 hold bits 23..16, 15..8 and 7..0 of the baud divisor. A write to one of these addresses loads only that byte. A read returns that byte.
- R3: Addresses 3, 7, 8, 9, 10 and 11 are plain 8-bit registers (line control, transmit low watermark, receive high watermark, receive low watermark, receive timeout, inter-character delay). Each reads back the last value written to it.
- R4: A write to address 4 ORs the written byte into the interrupt mask.
- R5: A write to address 5 clears every mask bit that is 1 in the written byte. A read of address 5 returns the current mask.
- R6: A write to address 6 pushes {1'b1, byte} into the transmit queue. `txHeadData` shows the oldest entry while `txHeadValid` is high, and `txPop` removes that entry.
- R7: A write to address 12 pushes {1'b0, byte} into the transmit queue, in order with data entries.
- R8: A read of address 6 returns the oldest byte pushed through `rxPush`/`rxData` and removes it. Exactly one byte is removed per acknowledged read.
- R9: A read of address 6 while the receive queue is empty returns 0 and removes nothing.
- R10: A read of address 4 returns the status byte. The bits are: bit0 transmit full, bit1 transmit empty, bit2 receive not empty, bit3 receive full, bit4 transmit overflow, bits 7..5 = `extStatus`. Writes to address 4 never alter the status byte.
- R11: A push into a full transmit queue is dropped and sets status bit4. Bit4 stays set until reset.
- R12: Only `wbDatIn[7:0]` is used. `wbDatOut[31:8]` is always 0, and reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wbCyc | input | 1 | Bus cycle active |
| wbStb | input | 1 | Bus strobe |
| wbWe | input | 1 | Write enable |
| wbAdr | input | 4 | Word address |
| wbDatIn | input | 32 | Write data (low byte used) |
| wbDatOut | output | 32 | Read data |
| wbAck | output | 1 | Acknowledge |
| rxPush | input | 1 | Received byte strobe from the shifter |
| rxData | input | 8 | Received byte |
| txPop | input | 1 | Shifter takes the transmit head |
| txHeadValid | output | 1 | Transmit queue not empty |
| txHeadData | output | 9 | Oldest transmit entry, bit8 = data (1) or break (0) |
| extStatus | input | 3 | External status bits shown in status bits 7..5 |

## Verification
The bench first pushes two received bytes and drains them. It then reads the empty queue and follows with one more byte. A design that pops on an empty read, or that pops twice per read, returns a stale or shifted byte there. Set and clear are applied to overlapping mask patterns, so a design that overwrites the mask instead of merging the byte gives a different readback. Data and break writes are interleaved and then drained from the transmit head, which exposes a wrong bit 8 tag or a wrong order. A fifth push into the four-entry queue checks that the entry is dropped and that the overflow flag survives the draining of the queue and clears only on reset.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
  localparam int ADDR_W = 4;
  localparam int BYTE_W = 8;

  localparam logic [ADDR_W-1:0] A_BAUD_HI  = 4'd0;
  localparam logic [ADDR_W-1:0] A_BAUD_MID = 4'd1;
  localparam logic [ADDR_W-1:0] A_BAUD_LO  = 4'd2;
  localparam logic [ADDR_W-1:0] A_LINE     = 4'd3;
  localparam logic [ADDR_W-1:0] A_STAT_SET = 4'd4;
  localparam logic [ADDR_W-1:0] A_MASK_CLR = 4'd5;
  localparam logic [ADDR_W-1:0] A_DATA     = 4'd6;
  localparam logic [ADDR_W-1:0] A_TX_LOW   = 4'd7;
  localparam logic [ADDR_W-1:0] A_RX_HIGH  = 4'd8;
  localparam logic [ADDR_W-1:0] A_RX_LOW   = 4'd9;
  localparam logic [ADDR_W-1:0] A_TIMEOUT  = 4'd10;
  localparam logic [ADDR_W-1:0] A_ICD      = 4'd11;
  localparam logic [ADDR_W-1:0] A_BREAK    = 4'd12;

  typedef struct packed {
    logic [2:0] loadBaud;   // [2]=bits 23..16, [1]=15..8, [0]=7..0
    logic       loadLine;
    logic       maskSet;
    logic       maskClr;
    logic       pushData;
    logic       pushBreak;
    logic       loadTxLow;
    logic       loadRxHigh;
    logic       loadRxLow;
    logic       loadTimeout;
    logic       loadIcd;
    logic       rxPop;
  } regStrobe_t;
endpackage

// File: rtl/uart_reg_fifo.sv
module uart_reg_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic doPush, doPop;

  assign empty    = (count == '0);
  assign full     = (count == CNT_MAX);
  assign doPush   = push && !full;
  assign doPop    = pop && !empty;
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) begin
        mem[wrPtr] <= pushData;
        wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      end
      if (doPop) rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_MAX);
  p_full_holds_r11: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> full);
endmodule

// File: rtl/uart_reg_ctrl.sv
module uart_reg_ctrl
  import uart_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wbCyc,
  input  logic              wbStb,
  input  logic              wbWe,
  input  logic [ADDR_W-1:0] wbAdr,
  input  logic              rxNotEmpty,
  output logic              wbAck,
  output logic              rdActive,
  output regStrobe_t        strobe
);
  logic access;

  always_ff @(posedge clk) begin
    if (rst) wbAck <= 1'b0;
    else     wbAck <= wbCyc && wbStb && !wbAck;
  end

  assign access   = wbCyc && wbStb && wbAck;
  assign rdActive = access && !wbWe;

  always_comb begin
    strobe = '0;
    if (access && wbWe) begin
      case (wbAdr)
        A_BAUD_HI:  strobe.loadBaud[2] = 1'b1;
        A_BAUD_MID: strobe.loadBaud[1] = 1'b1;
        A_BAUD_LO:  strobe.loadBaud[0] = 1'b1;
        A_LINE:     strobe.loadLine    = 1'b1;
        A_STAT_SET: strobe.maskSet     = 1'b1;
        A_MASK_CLR: strobe.maskClr     = 1'b1;
        A_DATA:     strobe.pushData    = 1'b1;
        A_TX_LOW:   strobe.loadTxLow   = 1'b1;
        A_RX_HIGH:  strobe.loadRxHigh  = 1'b1;
        A_RX_LOW:   strobe.loadRxLow   = 1'b1;
        A_TIMEOUT:  strobe.loadTimeout = 1'b1;
        A_ICD:      strobe.loadIcd     = 1'b1;
        A_BREAK:    strobe.pushBreak   = 1'b1;
        default:    strobe = '0;
      endcase
    end
    if (rdActive && wbAdr == A_DATA && rxNotEmpty) strobe.rxPop = 1'b1;
  end

  p_ack_after_req_r1: assert property (@(posedge clk) disable iff (rst)
    wbAck |-> $past(wbCyc && wbStb));
  p_ack_single_r1: assert property (@(posedge clk) disable iff (rst)
    wbAck |=> !wbAck);
  p_no_pop_empty_r9: assert property (@(posedge clk) disable iff (rst)
    strobe.rxPop |-> rxNotEmpty);
endmodule

// File: rtl/uart_reg_dpath.sv
module uart_reg_dpath
  import uart_reg_pkg::*;
#(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  regStrobe_t        strobe,
  input  logic [BYTE_W-1:0] wrByte,
  input  logic              rdActive,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              rxPush,
  input  logic [BYTE_W-1:0] rxData,
  input  logic              txPop,
  input  logic [2:0]        extStatus,
  output logic [BYTE_W-1:0] readByte,
  output logic              rxNotEmpty,
  output logic              txHeadValid,
  output logic [BYTE_W:0]   txHeadData
);
  localparam int BAUD_BYTES = 3;

  logic [BYTE_W-1:0] baudReg [BAUD_BYTES];
  logic [BYTE_W-1:0] lineReg, maskReg, txLowReg, rxHighReg, rxLowReg, timeoutReg, icdReg;
  logic              txOvf;
  logic              txFull, txEmpty, rxFull, rxEmpty, txPush;
  logic [BYTE_W-1:0] rxHead;
  logic [BYTE_W-1:0] statusByte;

  for (genvar b = 0; b < BAUD_BYTES; b++) begin : g_baud
    always_ff @(posedge clk) begin
      if (rst)                    baudReg[b] <= '0;
      else if (strobe.loadBaud[b]) baudReg[b] <= wrByte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lineReg <= '0; maskReg <= '0; txLowReg <= '0; rxHighReg <= '0;
      rxLowReg <= '0; timeoutReg <= '0; icdReg <= '0; txOvf <= 1'b0;
    end else begin
      if (strobe.loadLine)    lineReg    <= wrByte;
      if (strobe.loadTxLow)   txLowReg   <= wrByte;
      if (strobe.loadRxHigh)  rxHighReg  <= wrByte;
      if (strobe.loadRxLow)   rxLowReg   <= wrByte;
      if (strobe.loadTimeout) timeoutReg <= wrByte;
      if (strobe.loadIcd)     icdReg     <= wrByte;
      if (strobe.maskSet)      maskReg <= maskReg | wrByte;
      else if (strobe.maskClr) maskReg <= maskReg & ~wrByte;
      if (txPush && txFull)   txOvf <= 1'b1;
    end
  end

  assign txPush = strobe.pushData || strobe.pushBreak;

  uart_reg_fifo #(.WIDTH(BYTE_W + 1), .DEPTH(TX_DEPTH)) txQueue (
    .clk(clk), .rst(rst), .push(txPush), .pushData({strobe.pushData, wrByte}),
    .pop(txPop), .headData(txHeadData), .empty(txEmpty), .full(txFull));

  uart_reg_fifo #(.WIDTH(BYTE_W), .DEPTH(RX_DEPTH)) rxQueue (
    .clk(clk), .rst(rst), .push(rxPush), .pushData(rxData),
    .pop(strobe.rxPop), .headData(rxHead), .empty(rxEmpty), .full(rxFull));

  assign txHeadValid = !txEmpty;
  assign rxNotEmpty  = !rxEmpty;
  assign statusByte  = {extStatus, txOvf, rxFull, !rxEmpty, txEmpty, txFull};

  always_comb begin
    readByte = '0;
    if (rdActive) begin
      case (rdAddr)
        A_BAUD_HI:  readByte = baudReg[2];
        A_BAUD_MID: readByte = baudReg[1];
        A_BAUD_LO:  readByte = baudReg[0];
        A_LINE:     readByte = lineReg;
        A_STAT_SET: readByte = statusByte;
        A_MASK_CLR: readByte = maskReg;
        A_DATA:     readByte = rxEmpty ? '0 : rxHead;
        A_TX_LOW:   readByte = txLowReg;
        A_RX_HIGH:  readByte = rxHighReg;
        A_RX_LOW:   readByte = rxLowReg;
        A_TIMEOUT:  readByte = timeoutReg;
        A_ICD:      readByte = icdReg;
        default:    readByte = '0;
      endcase
    end
  end

  p_mask_set_r4: assert property (@(posedge clk) disable iff (rst)
    strobe.maskSet |=> ((maskReg & $past(wrByte)) == $past(wrByte)));
  p_mask_clr_r5: assert property (@(posedge clk) disable iff (rst)
    strobe.maskClr |=> ((maskReg & $past(wrByte)) == '0));
  p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    txOvf |=> txOvf);
  p_ovf_cause_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(txOvf) |-> $past(txFull && txPush));
endmodule

// File: rtl/wb_uart_regs.sv
module wb_uart_regs
  import uart_reg_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wbCyc,
  input  logic              wbStb,
  input  logic              wbWe,
  input  logic [ADDR_W-1:0] wbAdr,
  input  logic [DATA_W-1:0] wbDatIn,
  output logic [DATA_W-1:0] wbDatOut,
  output logic              wbAck,
  input  logic              rxPush,
  input  logic [BYTE_W-1:0] rxData,
  input  logic              txPop,
  output logic              txHeadValid,
  output logic [BYTE_W:0]   txHeadData,
  input  logic [2:0]        extStatus
);
  regStrobe_t        strobe;
  logic              rdActive, rxNotEmpty;
  logic [BYTE_W-1:0] readByte;

  uart_reg_ctrl ctrl (
    .clk(clk), .rst(rst), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
    .wbAdr(wbAdr), .rxNotEmpty(rxNotEmpty), .wbAck(wbAck),
    .rdActive(rdActive), .strobe(strobe));

  uart_reg_dpath #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) dpath (
    .clk(clk), .rst(rst), .strobe(strobe), .wrByte(wbDatIn[BYTE_W-1:0]),
    .rdActive(rdActive), .rdAddr(wbAdr), .rxPush(rxPush), .rxData(rxData),
    .txPop(txPop), .extStatus(extStatus), .readByte(readByte),
    .rxNotEmpty(rxNotEmpty), .txHeadValid(txHeadValid), .txHeadData(txHeadData));

  assign wbDatOut = {{(DATA_W-BYTE_W){1'b0}}, readByte};
endmodule

// File: tb/wb_uart_regs_test.sv
module wb_uart_regs_test;
  logic clk = 1'b0, rst = 1'b1;
  logic wbCyc = 0, wbStb = 0, wbWe = 0;
  logic [3:0] wbAdr = '0;
  logic [31:0] wbDatIn = '0;
  logic [31:0] wbDatOut;
  logic wbAck;
  logic rxPush = 0, txPop = 0;
  logic [7:0] rxData = '0;
  logic txHeadValid;
  logic [8:0] txHeadData;
  logic [2:0] extStatus = '0;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  logic [31:0] expQ[$];
  string reqQ[$];

  always #10 clk = ~clk;

  wb_uart_regs uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: compare every read response with the scoreboard head
  always @(negedge clk) begin
    if (wbAck && !wbWe && expQ.size() > 0) begin
      automatic logic [31:0] e = expQ.pop_front();
      automatic string r = reqQ.pop_front();
      check(r, wbDatOut, e);
    end
  end

  task automatic busCycle(input logic we, input logic [3:0] adr, input logic [31:0] dat);
    @(posedge clk); #2;
    wbCyc = 1; wbStb = 1; wbWe = we; wbAdr = adr; wbDatIn = dat;
    @(negedge clk); check("R1 no ack yet", {31'b0, wbAck}, 32'd0);
    @(posedge clk);
    @(negedge clk); check("R1 ack", {31'b0, wbAck}, 32'd1);
    @(posedge clk); #2;
    wbCyc = 0; wbStb = 0; wbWe = 0;
    @(negedge clk); check("R1 ack single", {31'b0, wbAck}, 32'd0);
  endtask

  task automatic wbWrite(input logic [3:0] adr, input logic [31:0] dat);
    busCycle(1'b1, adr, dat);
  endtask

  task automatic wbRead(input logic [3:0] adr, input logic [7:0] exp, input string req);
    expQ.push_back({24'b0, exp});
    reqQ.push_back(req);
    busCycle(1'b0, adr, 32'h0);
  endtask

  task automatic pushRx(input logic [7:0] b);
    @(posedge clk); #2; rxPush = 1; rxData = b;
    @(posedge clk); #2; rxPush = 0;
  endtask

  task automatic popTx(input logic [8:0] exp, input string req);
    @(negedge clk);
    check(req, {23'b0, txHeadValid, txHeadData}, {23'b0, 1'b1, exp});
    @(posedge clk); #2; txPop = 1;
    @(posedge clk); #2; txPop = 0;
  endtask

  task automatic doReset();
    @(posedge clk); #2; rst = 1;
    repeat (2) @(posedge clk);
    #2; rst = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      miscompares++; vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2; rst = 0;
    @(negedge clk);
    check("R1 reset ack", {31'b0, wbAck}, 32'd0);
    check("R6 reset tx empty", {31'b0, txHeadValid}, 32'd0);
    wbRead(4'd0, 8'h00, "R2 reset baud");
    wbRead(4'd4, 8'h02, "R10 reset status");

    // R2 baud bytes independent
    wbWrite(4'd0, 32'h12); wbWrite(4'd1, 32'h34); wbWrite(4'd2, 32'h56);
    wbRead(4'd0, 8'h12, "R2 baud hi"); wbRead(4'd1, 8'h34, "R2 baud mid");
    wbRead(4'd2, 8'h56, "R2 baud lo");
    wbWrite(4'd1, 32'hAB);
    wbRead(4'd0, 8'h12, "R2 hi kept"); wbRead(4'd1, 8'hAB, "R2 mid new");

    // R3 plain registers
    for (int a = 7; a <= 11; a++) wbWrite(4'(a), 32'(8'h40 + a));
    wbWrite(4'd3, 32'hFFFF_FF77);
    for (int a = 7; a <= 11; a++) wbRead(4'(a), 8'(8'h40 + a), "R3 readback");
    wbRead(4'd3, 8'h77, "R3 R12 line low byte only");
    wbRead(4'd13, 8'h00, "R12 unmapped");

    // R4 / R5 mask
    wbWrite(4'd4, 32'h0F); wbRead(4'd5, 8'h0F, "R4 set");
    wbWrite(4'd4, 32'h30); wbRead(4'd5, 8'h3F, "R4 set merge");
    wbWrite(4'd5, 32'h05); wbRead(4'd5, 8'h3A, "R5 clear");
    wbRead(4'd4, 8'h02, "R10 status unchanged by write");

    // R6 / R7 tagged transmit entries
    wbWrite(4'd6, 32'hA5); wbWrite(4'd12, 32'h00); wbWrite(4'd6, 32'h3C);
    popTx(9'h1A5, "R6 data tag"); popTx(9'h000, "R7 break tag");
    popTx(9'h13C, "R6 order");

    // R8 / R9 receive queue
    pushRx(8'h11); pushRx(8'h22);
    wbRead(4'd4, 8'h06, "R10 rx not empty");
    wbRead(4'd6, 8'h11, "R8 oldest"); wbRead(4'd6, 8'h22, "R8 second");
    wbRead(4'd6, 8'h00, "R9 empty read");
    pushRx(8'h33);
    wbRead(4'd6, 8'h33, "R9 no pop on empty");
    wbRead(4'd6, 8'h00, "R8 single pop");

    // R11 overflow
    for (int i = 1; i <= 5; i++) wbWrite(4'd6, 32'(i));
    wbRead(4'd4, 8'h11, "R11 full and overflow");
    for (int i = 1; i <= 4; i++) popTx({1'b1, 8'(i)}, "R11 fifth dropped");
    @(negedge clk); check("R11 queue drained", {31'b0, txHeadValid}, 32'd0);
    wbRead(4'd4, 8'h12, "R11 sticky");
    extStatus = 3'b101;
    wbRead(4'd4, 8'hB2, "R10 ext status");
    doReset();
    extStatus = 3'b000;
    wbRead(4'd4, 8'h02, "R11 cleared by reset");

    repeat (3) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule